// File: doc/BRIEF.md
# Per-Class Receive Limit Broadcaster

This block sits on the application side of a PCIe-style transaction layer. It tells the link logic how many receive TLPs the application can still accept in each of three traffic classes: posted, non-posted and completion. Each class has a 12-bit running limit. At reset the limit is loaded with that class's buffer depth, counted in TLPs. The limit then moves up by one every time the application drains one TLP of that class from its buffer. The value only ever increments and wraps modulo 4096. A consumer compares it against its own running count of TLPs sent and gets the free space without ever needing a decrement.

The three limits share one 12-bit bus and take one slot each. A 2-bit class tag travels with the bus. A small state machine with three states, `SLOT_P`, `SLOT_NP` and `SLOT_CPL`, picks the class. Its only transitions are `SLOT_P -> SLOT_NP`, `SLOT_NP -> SLOT_CPL` and `SLOT_CPL -> SLOT_P`, one on every clock edge outside reset. Synchronous reset forces `SLOT_P`. The per-class depths are parameters. A depth above 2048 stops elaboration.

Top module: `rxlim_tdm_reporter`

## Requirements
- R1: While reset is high, and on the first sample after it, the class tag reads 2'b00 and the bus carries the posted depth. Each class limit equals its configured depth after any reset, including one applied mid-run.
- R2: Outside reset the tag steps posted (2'b00) -> non-posted (2'b01) -> completion (2'b10) -> posted on every clock edge. It never shows 2'b11.
- R3: In every cycle the bus value is the current limit of the class named by the tag on that same cycle. Tag and value switch on the same edge.
- R4: A high release strobe for a class on a clock edge (rel_i bit 0 = posted, bit 1 = non-posted, bit 2 = completion) raises that class's limit by exactly one.
- R5: Strobes for several classes in the same cycle each advance their own limit by one, independently.
- R6: A limit of 12'hFFF that receives a strobe becomes 12'h000.
- R7: A class whose strobe is low keeps its limit, whatever the other strobes do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rel_i | input | 3 | Per-class TLP-released strobes: bit 0 posted, bit 1 non-posted, bit 2 completion |
| lim_o | output | 12 | Limit of the class currently in its slot |
| lim_cls_o | output | 2 | Class tag for lim_o: 00 posted, 01 non-posted, 10 completion |

## Verification
The bench builds the block with a posted depth of 2048, a non-posted depth of 16 and a completion depth of 1. Starting the posted limit at the largest legal depth means a few thousand strobes carry it past 12'hFFF to 12'h000 within the run. The three depths differ, so any mix-up between a tag and the wrong counter shows up on the bus. The depth of 1 covers the smallest buffer, and mixed strobe patterns in the same cycles test that the counters advance independently.

// File: rtl/rxlim_pkg.sv
package rxlim_pkg;

    localparam int LIM_W     = 12;
    localparam int N_CLS     = 3;
    localparam int MAX_DEPTH = 2048;

    typedef enum logic [1:0] {
        CLS_P   = 2'b00,
        CLS_NP  = 2'b01,
        CLS_CPL = 2'b10
    } cls_e;

endpackage

// File: rtl/rxlim_class_counter.sv
module rxlim_class_counter #(
    parameter int W         = 12,
    parameter int INIT      = 0,
    parameter int MAX_DEPTH = 2048
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] INIT_V = W'(INIT);

    if (INIT > MAX_DEPTH) begin : g_bad_depth
        $error("rxlim_class_counter: initial depth exceeds the allowed maximum");
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_o <= INIT_V;
        end else if (inc_i) begin
            cnt_o <= cnt_o + 1'b1;
        end
    end

endmodule

// File: rtl/rxlim_slot_fsm.sv
module rxlim_slot_fsm
    import rxlim_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    output cls_e cls_o
);

    typedef enum logic [1:0] {
        SLOT_P   = 2'd0,
        SLOT_NP  = 2'd1,
        SLOT_CPL = 2'd2
    } slot_e;

    slot_e state_q;
    slot_e state_d;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= SLOT_P;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            SLOT_P:   state_d = SLOT_NP;
            SLOT_NP:  state_d = SLOT_CPL;
            SLOT_CPL: state_d = SLOT_P;
            default:  state_d = SLOT_P;
        endcase
    end

    always_comb begin
        unique case (state_q)
            SLOT_P:   cls_o = CLS_P;
            SLOT_NP:  cls_o = CLS_NP;
            SLOT_CPL: cls_o = CLS_CPL;
            default:  cls_o = CLS_P;
        endcase
    end

endmodule

// File: rtl/rxlim_tdm_reporter.sv
module rxlim_tdm_reporter
    import rxlim_pkg::*;
#(
    parameter int P_DEPTH   = 256,
    parameter int NP_DEPTH  = 64,
    parameter int CPL_DEPTH = 128
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [N_CLS-1:0] rel_i,
    output logic [LIM_W-1:0] lim_o,
    output logic [1:0]       lim_cls_o
);

    logic [LIM_W-1:0] cnt [N_CLS];
    cls_e             cls;

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        localparam int DEPTH_C = (c == 0) ? P_DEPTH :
                                 (c == 1) ? NP_DEPTH : CPL_DEPTH;
        rxlim_class_counter #(
            .W         (LIM_W),
            .INIT      (DEPTH_C),
            .MAX_DEPTH (MAX_DEPTH)
        ) u_cnt (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .inc_i (rel_i[c]),
            .cnt_o (cnt[c])
        );
    end

    rxlim_slot_fsm u_fsm (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .cls_o (cls)
    );

    always_comb begin
        unique case (cls)
            CLS_P:   lim_o = cnt[0];
            CLS_NP:  lim_o = cnt[1];
            CLS_CPL: lim_o = cnt[2];
            default: lim_o = cnt[0];
        endcase
    end

    assign lim_cls_o = cls;

endmodule

// File: rtl/rxlim_tdm_reporter_chk.sv
module rxlim_tdm_reporter_chk #(
    parameter int W = 12
) (
    input logic         clk_i,
    input logic         rst_i,
    input logic [2:0]   rel_i,
    input logic [1:0]   lim_cls_o,
    input logic [W-1:0] cnt_p,
    input logic [W-1:0] cnt_np,
    input logic [W-1:0] cnt_cpl
);

    AST_CLS_LEGAL: assert property (@(posedge clk_i) disable iff (rst_i)
        lim_cls_o != 2'b11);                                                    // R2
    AST_ROT_P_NP: assert property (@(posedge clk_i) disable iff (rst_i)
        lim_cls_o == 2'b00 |=> lim_cls_o == 2'b01);                             // R2
    AST_ROT_NP_CPL: assert property (@(posedge clk_i) disable iff (rst_i)
        lim_cls_o == 2'b01 |=> lim_cls_o == 2'b10);                             // R2
    AST_ROT_CPL_P: assert property (@(posedge clk_i) disable iff (rst_i)
        lim_cls_o == 2'b10 |=> lim_cls_o == 2'b00);                             // R2
    AST_P_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        rel_i[0] |=> cnt_p == W'($past(cnt_p) + 1'b1));                         // R4
    AST_NP_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        rel_i[1] |=> cnt_np == W'($past(cnt_np) + 1'b1));                       // R4
    AST_CPL_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        rel_i[2] |=> cnt_cpl == W'($past(cnt_cpl) + 1'b1));                     // R4
    AST_P_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !rel_i[0] |=> $stable(cnt_p));                                          // R7
    AST_NP_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !rel_i[1] |=> $stable(cnt_np));                                         // R7
    AST_CPL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !rel_i[2] |=> $stable(cnt_cpl));                                        // R7

endmodule

bind rxlim_tdm_reporter rxlim_tdm_reporter_chk #(.W(rxlim_pkg::LIM_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .rel_i     (rel_i),
    .lim_cls_o (lim_cls_o),
    .cnt_p     (cnt[0]),
    .cnt_np    (cnt[1]),
    .cnt_cpl   (cnt[2])
);

// File: tb/rxlim_tdm_reporter_bench.sv
`timescale 1ns/1ps
module rxlim_tdm_reporter_bench;

    localparam int P_D   = 2048;
    localparam int NP_D  = 16;
    localparam int CPL_D = 1;

    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [2:0]  rel_i = 3'b000;
    logic [11:0] lim_o;
    logic [1:0]  lim_cls_o;

    int nchk  = 0;
    int nfail = 0;

    logic [11:0] m_lim [3];
    int          m_slot;

    always #2 clk_i = ~clk_i;

    rxlim_tdm_reporter #(
        .P_DEPTH   (P_D),
        .NP_DEPTH  (NP_D),
        .CPL_DEPTH (CPL_D)
    ) u_rxlim_tdm_reporter (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .rel_i     (rel_i),
        .lim_o     (lim_o),
        .lim_cls_o (lim_cls_o)
    );

    task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic model_reset();
        m_lim[0] = 12'(P_D);
        m_lim[1] = 12'(NP_D);
        m_lim[2] = 12'(CPL_D);
        m_slot   = 0;
    endtask

    // one clock: drive at negedge, model at posedge, check at next negedge (R3)
    task automatic step(input logic [2:0] rel);
        rel_i = rel;
        @(posedge clk_i);
        if (rst_i) begin
            model_reset();
        end else begin
            for (int c = 0; c < 3; c++)
                if (rel[c]) m_lim[c] = m_lim[c] + 12'd1;
            m_slot = (m_slot == 2) ? 0 : m_slot + 1;
        end
        @(negedge clk_i);
        check("R2 tag", {10'd0, lim_cls_o}, 12'(m_slot));
        check("R3 value", lim_o, m_lim[m_slot]);
        rel_i = 3'b000;
    endtask

    task automatic see_class(input logic [1:0] cls, input logic [11:0] exp, input string tag);
        for (int i = 0; i < 3 && lim_cls_o != cls; i++) step(3'b000);
        check(tag, lim_o, exp);
    endtask

    task automatic t_reset_state();
        for (int i = 0; i < 3; i++) step(3'b111);
        check("R1 tag in reset", {10'd0, lim_cls_o}, 12'd0);
        check("R1 posted depth in reset", lim_o, 12'h800);
    endtask

    task automatic t_rotation();
        rst_i = 1'b0;
        check("R1 tag after release", {10'd0, lim_cls_o}, 12'd0);
        for (int i = 0; i < 6; i++) begin
            step(3'b000);
            check("R2 rotation", {10'd0, lim_cls_o}, 12'((i + 1) % 3));
        end
        see_class(2'b01, 12'd16, "R1 np depth");
        see_class(2'b10, 12'd1,  "R1 cpl depth");
    endtask

    task automatic t_single();
        for (int i = 0; i < 3; i++) step(3'b010);
        see_class(2'b01, 12'd19,  "R4 np after three strobes");
        see_class(2'b00, 12'h800, "R7 posted untouched");
        see_class(2'b10, 12'd1,   "R7 cpl untouched");
    endtask

    task automatic t_simul();
        step(3'b111);
        step(3'b111);
        step(3'b101);
        see_class(2'b00, 12'h803, "R5 posted joint");
        see_class(2'b01, 12'd21,  "R5 np joint");
        see_class(2'b10, 12'd4,   "R5 cpl joint");
    endtask

    task automatic t_wrap();
        for (int i = 0; i < 2044; i++) step(3'b001);
        see_class(2'b00, 12'hFFF, "R6 posted at top");
        step(3'b001);
        see_class(2'b00, 12'h000, "R6 posted wrapped");
        see_class(2'b01, 12'd21,  "R7 np through wrap");
    endtask

    task automatic t_mid_reset();
        rst_i = 1'b1;
        step(3'b011);
        step(3'b000);
        check("R1 tag mid reset", {10'd0, lim_cls_o}, 12'd0);
        check("R1 posted reload", lim_o, 12'h800);
        rst_i = 1'b0;
        see_class(2'b01, 12'd16, "R1 np reload");
        see_class(2'b10, 12'd1,  "R1 cpl reload");
    endtask

    initial begin
        model_reset();
        @(negedge clk_i);
        t_reset_state();
        t_rotation();
        t_single();
        t_simul();
        t_wrap();
        t_mid_reset();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        nchk++;
        nfail++;
        $display("FAIL watchdog got=hung expected=done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule